// File: doc/BRIEF.md
# Accumulator ALU with carry

This block is the 8-bit arithmetic and logic datapath of a small accumulator-based controller. It has no clock and no state. Each cycle the caller presents an operation code, the current accumulator, the carry flag and three candidate operands: a working-register byte, a byte read indirectly from memory and an immediate byte. A source select picks one of the three. The block returns the next accumulator value, the next carry value and a carry-update strobe. The caller registers these on its own write enable.

The low-nibble exchange always works on the memory byte, because it must write memory back. For that operation the block also returns a rewritten memory byte and a memory-write strobe. For every other operation the memory byte passes through unchanged.

Only the two additions, the two rotates through carry and the two explicit carry operations raise the carry strobe. Every other operation reflects the incoming carry unchanged.

Top module: `acc_alu_top`

## Requirements
- R1: Code 0 (add) gives `acc_o` = low 8 bits of acc + operand. Code 1 (add with carry) gives the low 8 bits of acc + operand + carry. For both, `cy_o` is bit 8 of that 9-bit unsigned sum.
- R2: `src_i` picks the operand for codes 0 to 4: 0 picks `reg_i`, 1 picks `mem_i`, 2 picks `imm_i`, and 3 picks `reg_i`.
- R3: Codes 2, 3 and 4 give acc AND, OR and XOR operand respectively.
- R4: Code 5 gives ~acc. Code 6 gives 0. Code 7 gives acc+1 and code 8 gives acc-1, both wrapping modulo 256.
- R5: Code 9 rotates acc left by one bit inside 8 bits. Code 11 rotates it right by one bit. Code 13 exchanges acc[3:0] with acc[7:4].
- R6: Code 10 gives `acc_o` = {acc[6:0], carry} and `cy_o` = acc[7]. Code 12 gives `acc_o` = {carry, acc[7:1]} and `cy_o` = acc[0].
- R7: Code 14 (decimal adjust) works in two steps. First, t = acc + 6 if acc[3:0] > 9, otherwise t = acc, computed in 9 bits. Then 0x60 is added to t[7:0] if t[7:4] > 9, t[8] is 1, or the carry input is 1. The result is taken modulo 256.
- R8: Code 15 gives `acc_o` = {acc[7:4], mem_i[3:0]} and `mem_o` = {mem_i[7:4], acc[3:0]}, with `mem_we_o` = 1.
- R9: For every code other than 15, `mem_o` equals `mem_i` and `mem_we_o` is 0.
- R10: Code 16 gives `cy_o` = 0 and code 17 gives `cy_o` = ~carry. For both, `acc_o` equals acc.
- R11: Codes 18 to 31 leave `acc_o` equal to acc and do not update carry.
- R12: `cy_we_o` is 1 exactly for codes 0, 1, 10, 12, 16 and 17. Whenever it is 0, `cy_o` equals `cy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| src_i | input | 2 | Operand source select |
| acc_i | input | 8 | Current accumulator |
| reg_i | input | 8 | Working-register operand |
| mem_i | input | 8 | Indirect memory operand |
| imm_i | input | 8 | Immediate operand |
| cy_i | input | 1 | Current carry flag |
| acc_o | output | 8 | Next accumulator |
| cy_o | output | 1 | Next carry flag |
| cy_we_o | output | 1 | Carry update strobe |
| mem_o | output | 8 | Next memory byte |
| mem_we_o | output | 1 | Memory write strobe |

## Verification
The block holds no state, so any fault shows in the same cycle that exposes it. A wrong operand select, a wrong carry path or a wrong strobe decode changes `acc_o`, `cy_o` or a strobe for that very code and input. The bench sweeps every code with many operand, source and carry combinations, so a fault shows within the first few vectors of the affected code. Corner values such as 0xFF plus 1, decimal adjust on nibbles above 9, and carry set during carry-free operations are applied on purpose, because off-by-one faults surface there first.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_AND  = 5'd2,
    OP_OR   = 5'd3,
    OP_XOR  = 5'd4,
    OP_CPL  = 5'd5,
    OP_CLR  = 5'd6,
    OP_INC  = 5'd7,
    OP_DEC  = 5'd8,
    OP_RL   = 5'd9,
    OP_RLC  = 5'd10,
    OP_RR   = 5'd11,
    OP_RRC  = 5'd12,
    OP_SWAP = 5'd13,
    OP_DA   = 5'd14,
    OP_XCHD = 5'd15,
    OP_CLRC = 5'd16,
    OP_CPLC = 5'd17,
    OP_NOP  = 5'd18
  } alu_op_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   acc,
  input  logic [W-1:0]   opnd,
  input  logic           cy_in,
  output logic [W-1:0]   res,
  output logic           cy_out
);
  localparam int NIB = W / 2;
  localparam logic [W-1:0] ONE     = W'(1);
  localparam logic [W:0]   LO_FIX  = (W+1)'(6);
  localparam logic [W-1:0] HI_FIX  = W'(6 << NIB);
  localparam logic [NIB-1:0] NINE  = NIB'(9);

  logic [W:0] sum;
  logic [W:0] da_stage;
  logic       da_hi;

  always_comb begin
    sum      = {1'b0, acc} + {1'b0, opnd} + {{W{1'b0}}, (op == OP_ADDC) & cy_in};
    da_stage = {1'b0, acc} + ((acc[NIB-1:0] > NINE) ? LO_FIX : '0);
    da_hi    = da_stage[W] | cy_in | (da_stage[W-1:NIB] > NINE);
    res      = acc;
    cy_out   = cy_in;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        res    = sum[W-1:0];
        cy_out = sum[W];
      end
      OP_INC:  res = acc + ONE;
      OP_DEC:  res = acc - ONE;
      OP_DA:   res = da_stage[W-1:0] + (da_hi ? HI_FIX : '0);
      default: res = acc;
    endcase
  end

  always_comb begin
    if (op == OP_INC) AST_INC_STEP: assert ((res - ONE) == acc) else $error("inc step"); // R4
    if (op == OP_DEC) AST_DEC_STEP: assert ((res + ONE) == acc) else $error("dec step"); // R4
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   acc,
  input  logic [W-1:0]   opnd,
  input  logic [W-1:0]   mem,
  input  logic           cy_in,
  output logic [W-1:0]   res,
  output logic           cy_out,
  output logic [W-1:0]   mem_out,
  output logic           mem_we
);
  localparam int NIB = W / 2;

  always_comb begin
    res     = acc;
    cy_out  = cy_in;
    mem_out = mem;
    mem_we  = 1'b0;
    unique case (op)
      OP_AND:  res = acc & opnd;
      OP_OR:   res = acc | opnd;
      OP_XOR:  res = acc ^ opnd;
      OP_CPL:  res = ~acc;
      OP_CLR:  res = '0;
      OP_RL:   res = {acc[W-2:0], acc[W-1]};
      OP_RR:   res = {acc[0], acc[W-1:1]};
      OP_RLC: begin
        res    = {acc[W-2:0], cy_in};
        cy_out = acc[W-1];
      end
      OP_RRC: begin
        res    = {cy_in, acc[W-1:1]};
        cy_out = acc[0];
      end
      OP_SWAP: res = {acc[NIB-1:0], acc[W-1:NIB]};
      OP_XCHD: begin
        res     = {acc[W-1:NIB], mem[NIB-1:0]};
        mem_out = {mem[W-1:NIB], acc[NIB-1:0]};
        mem_we  = 1'b1;
      end
      OP_CLRC: cy_out = 1'b0;
      OP_CPLC: cy_out = ~cy_in;
      default: res = acc;
    endcase
  end

  always_comb begin
    if (op == OP_RL || op == OP_RR || op == OP_SWAP)
      AST_ROT_ONES: assert ($countones(res) == $countones(acc)) else $error("rotate ones"); // R5
    if (op == OP_RLC || op == OP_RRC)
      AST_RC_NINE_BITS: assert ($countones({res, cy_out}) == $countones({acc, cy_in})) else $error("rc ones"); // R6
  end
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op_i,
  input  logic [1:0]   src_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] mem_i,
  input  logic [W-1:0] imm_i,
  input  logic         cy_i,
  output logic [W-1:0] acc_o,
  output logic         cy_o,
  output logic         cy_we_o,
  output logic [W-1:0] mem_o,
  output logic         mem_we_o
);
  localparam int NIB = W / 2;

  alu_op_e      op;
  logic [W-1:0] opnd;
  logic [W-1:0] a_res, l_res;
  logic         a_cy, l_cy;
  logic         is_arith;

  assign op = alu_op_e'(op_i);

  always_comb begin
    unique case (src_i)
      2'd1:    opnd = mem_i;
      2'd2:    opnd = imm_i;
      default: opnd = reg_i;
    endcase
  end

  acc_alu_arith #(.W(W)) u_arith (
    .op(op), .acc(acc_i), .opnd(opnd), .cy_in(cy_i),
    .res(a_res), .cy_out(a_cy)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op(op), .acc(acc_i), .opnd(opnd), .mem(mem_i), .cy_in(cy_i),
    .res(l_res), .cy_out(l_cy), .mem_out(mem_o), .mem_we(mem_we_o)
  );

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_INC) ||
               (op == OP_DEC) || (op == OP_DA);
    cy_we_o  = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_RLC) ||
               (op == OP_RRC) || (op == OP_CLRC) || (op == OP_CPLC);
    acc_o    = is_arith ? a_res : l_res;
    cy_o     = cy_we_o ? (is_arith ? a_cy : l_cy) : cy_i;
  end

  always_comb begin
    AST_MEM_HIGH_KEPT: assert (mem_o[W-1:NIB] == mem_i[W-1:NIB]) else $error("mem high"); // R8
    if (!mem_we_o)
      AST_MEM_PASS: assert (mem_o == mem_i) else $error("mem pass"); // R9
    if (mem_we_o)
      AST_MEM_ACC_HIGH: assert (acc_o[W-1:NIB] == acc_i[W-1:NIB]) else $error("xchd acc"); // R8
    if (!cy_we_o)
      AST_CARRY_HELD: assert (l_cy == cy_i || is_arith) else $error("carry held"); // R12
  end
endmodule

// File: tb/acc_alu_top_tb.sv
module acc_alu_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op;
  logic [1:0] src;
  logic [7:0] acc, rg, mem, imm;
  logic       cy;
  logic [7:0] acc_o, mem_o;
  logic       cy_o, cy_we_o, mem_we_o;
  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  acc_alu_top u_dut (
    .op_i(op), .src_i(src), .acc_i(acc), .reg_i(rg), .mem_i(mem), .imm_i(imm),
    .cy_i(cy), .acc_o(acc_o), .cy_o(cy_o), .cy_we_o(cy_we_o),
    .mem_o(mem_o), .mem_we_o(mem_we_o)
  );

  function automatic string tag(input int o);
    case (o)
      0, 1:          return "R1";
      2, 3, 4:       return "R3";
      5, 6, 7, 8:    return "R4";
      9, 11, 13:     return "R5";
      10, 12:        return "R6";
      14:            return "R7";
      15:            return "R8";
      16, 17:        return "R10";
      default:       return "R11";
    endcase
  endfunction

  // behavioural model: {acc, cy, cy_we, mem, mem_we}
  function automatic logic [18:0] model(input int o, input int s, input int a,
                                        input int r, input int m, input int i, input int c);
    int x, t, na, nc, we, nm, mwe, hf;
    x = (s == 1) ? m : (s == 2) ? i : r;   // R2
    na = a; nc = c; we = 0; nm = m; mwe = 0;
    case (o)
      0:  begin t = a + x;     na = t % 256; nc = t / 256; we = 1; end
      1:  begin t = a + x + c; na = t % 256; nc = t / 256; we = 1; end
      2:  na = a & x;
      3:  na = a | x;
      4:  na = a ^ x;
      5:  na = 255 - a;
      6:  na = 0;
      7:  na = (a + 1) % 256;
      8:  na = (a + 255) % 256;
      9:  na = (a * 2) % 256 + a / 128;
      10: begin na = (a * 2) % 256 + c; nc = a / 128; we = 1; end
      11: na = a / 2 + (a % 2) * 128;
      12: begin na = a / 2 + c * 128; nc = a % 2; we = 1; end
      13: na = (a % 16) * 16 + a / 16;
      14: begin
        t  = a + (((a % 16) > 9) ? 6 : 0);
        hf = (t > 255 || c == 1 || ((t / 16) % 16) > 9) ? 1 : 0;
        na = (t + hf * 96) % 256;
      end
      15: begin na = (a / 16) * 16 + m % 16; nm = (m / 16) * 16 + a % 16; mwe = 1; end
      16: begin nc = 0; we = 1; end
      17: begin nc = 1 - c; we = 1; end
      default: ;
    endcase
    return {8'(na), 1'(nc), 1'(we), 8'(nm), 1'(mwe)};
  endfunction

  task automatic apply(input int o, input int s, input int a, input int r,
                       input int m, input int i, input int c);
    logic [18:0] e;
    @(posedge clk);
    op = 5'(o); src = 2'(s); acc = 8'(a); rg = 8'(r); mem = 8'(m); imm = 8'(i); cy = 1'(c);
    @(negedge clk);
    e = model(o, s, a, r, m, i, c);
    vectors++;
    if (acc_o !== e[18:11]) begin
      misses++; $display("FAIL %s op=%0d acc_o actual %h expected %h", tag(o), o, acc_o, e[18:11]);
    end
    if (cy_o !== e[10]) begin
      misses++; $display("FAIL %s op=%0d cy_o actual %b expected %b", tag(o), o, cy_o, e[10]);
    end
    if (cy_we_o !== e[9]) begin
      misses++; $display("FAIL R12 op=%0d cy_we_o actual %b expected %b", o, cy_we_o, e[9]);
    end
    if (mem_o !== e[8:1] || mem_we_o !== e[0]) begin
      misses++; $display("FAIL R9 op=%0d mem actual %h/%b expected %h/%b", o, mem_o, mem_we_o, e[8:1], e[0]);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    op = 0; src = 0; acc = 0; rg = 0; mem = 0; imm = 0; cy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++; // reset state, R1: add of zeros
    if (acc_o !== 8'h00 || cy_o !== 1'b0 || cy_we_o !== 1'b1 || mem_we_o !== 1'b0) begin
      misses++; $display("FAIL R1 reset acc %h cy %b we %b actual, expected 00 0 1", acc_o, cy_o, cy_we_o);
    end
    rst_n = 1'b1;
    // directed corners
    apply(0, 2, 8'hFF, 0, 0, 8'h01, 0);      // R1 wrap to zero with carry
    apply(1, 0, 8'h7F, 8'h80, 0, 0, 1);      // R1 carry-in ripples
    apply(1, 1, 8'h00, 0, 8'hFF, 0, 1);      // R2 memory source
    apply(3, 3, 8'h0F, 8'hA0, 8'h55, 8'h33, 1); // R2 source 3 is register
    apply(7, 0, 8'hFF, 0, 0, 0, 1);          // R4 inc wrap, carry kept
    apply(8, 0, 8'h00, 0, 0, 0, 0);          // R4 dec wrap
    apply(10, 0, 8'h80, 0, 0, 0, 0);         // R6
    apply(12, 0, 8'h01, 0, 0, 0, 1);         // R6
    apply(14, 0, 8'h9A, 0, 0, 0, 0);         // R7 both nibbles adjust
    apply(14, 0, 8'h15, 0, 0, 0, 1);         // R7 carry forces high adjust
    apply(14, 0, 8'hFA, 0, 0, 0, 0);         // R7 low step overflows
    apply(15, 0, 8'h12, 0, 8'hAB, 0, 0);     // R8
    apply(16, 0, 8'h5A, 0, 0, 0, 1);         // R10
    apply(17, 0, 8'h5A, 0, 0, 0, 0);         // R10
    apply(31, 0, 8'hC3, 0, 8'h77, 0, 1);     // R11 unused code
    // sweep every code
    for (int o = 0; o < 32; o++) begin
      for (int k = 0; k < 150; k++) begin
        apply(o, int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 1)));
      end
    end
    summary();
  end
endmodule